// File: doc/BRIEF.md
# Masked Checksum Pattern Match Filter

This block watches a received Ethernet frame one byte at a time and decides whether the frame passes a content test. Byte 0 is the first byte of the destination address. A 64-byte window starts at a programmable even byte offset from byte 0. A 64-bit mask picks bytes out of that window. The picked bytes are summed as an Internet-style 16-bit one's-complement checksum, and the result is compared against an expected value.

Deselected bytes are dropped from the stream entirely, so the bytes that remain are packed together into 16-bit words. A frame that ends before the whole window has arrived always fails. This holds even when no mask bit is set.

The stream side carries a valid strobe plus start-of-frame and end-of-frame markers. End-of-frame flags the last FCS byte. One clock after the end-of-frame byte, the block raises a single-cycle result strobe together with a match flag. The offset, mask and expected value are captured when the start-of-frame byte arrives.

Top module: `pmf_match_top`

## Requirements
- R1: While reset is high and in the first cycle after it, res_valid and res_match are 0.
- R2: The byte accepted with in_sof is frame byte 0. The window covers frame bytes offset through offset+63, where offset is an even value.
- R3: Mask bit k (bit 0 = first window byte, bit 63 = last) set to 1 includes window byte k in the checksum. Set to 0, it excludes that byte.
- R4: An excluded byte is skipped rather than zeroed. The next included byte takes its place as the high or low half of the current word.
- R5: The checksum is the bitwise complement of the one's-complement sum, with end-around carry, of the included bytes read as big-endian 16-bit words. When the count of included bytes is odd, the last word gets a 00h low byte.
- R6: A frame matches only when the window is complete and the checksum equals cfg_expect.
- R7: If the end-of-frame byte has an index below offset+63, the result is no match, even with an all-zero mask.
- R8: res_valid is high for exactly the one cycle after each accepted end-of-frame byte, and only then. res_match is 0 whenever res_valid is 0.
- R9: cfg_offset, cfg_mask and cfg_expect are sampled with the start-of-frame byte. Changes later in the frame have no effect on that frame's result.
- R10: A start-of-frame byte that arrives inside an open frame abandons that frame without a result and starts a new frame at byte 0.
- R11: Cycles with in_valid low are ignored. Bytes that arrive between an end-of-frame and the next start-of-frame are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_sof | input | 1 | This byte is frame byte 0 |
| in_eof | input | 1 | This byte is the last FCS byte |
| in_data | input | 8 | Stream byte |
| cfg_offset | input | OFS_W | Window start, even byte index |
| cfg_mask | input | WIN_LEN | Per-byte include mask for the window |
| cfg_expect | input | 16 | Expected checksum |
| res_valid | output | 1 | One-cycle result strobe |
| res_match | output | 1 | Frame passed the test (valid with res_valid) |

## Verification
The bench covers five corner cases:

- **Frame length at the window edge.** Frames end exactly at offset+63 and one byte short of it. A design with an off-by-one length test would either reject a full window or accept a truncated one.
- **Sparse masks with odd byte counts.** These catch a design that zeroes skipped bytes or forgets the 00h pad. Either fault shifts the word pairing and changes the checksum.
- **All-zero mask on a short frame.** This exposes a design that lets the trivial FFFFh sum pass without checking length.
- **Configuration changes and restarts inside a frame.** The bench changes the configuration mid-frame and restarts frames with a fresh start-of-frame. Live sampling of the configuration shows up as wrong results, and stale accumulator state shows up as a stray or wrong strobe.
- **Stray bytes and valid-low gaps.** The bench sends idle cycles and bytes outside any frame. A design that counts these bytes misplaces the window.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef logic [WORD_W-1:0] word_t;

  // one's-complement add with the carry folded back in
  function automatic word_t oc_add(input word_t a, input word_t b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
  endfunction

endpackage

// File: rtl/pmf_window.sv
module pmf_window #(
  parameter int OFS_W   = 16,
  parameter int WIN_LEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [OFS_W-1:0]   cfg_offset,
  input  logic [WIN_LEN-1:0] cfg_mask,
  output logic               beat,
  output logic               restart,
  output logic               take,
  output logic               last,
  output logic               win_full,
  output logic               frame_open
);

  localparam int IDX_W = OFS_W + 1;
  localparam int REL_W = $clog2(WIN_LEN);
  localparam logic [IDX_W-1:0] LEN_I  = IDX_W'(WIN_LEN);
  localparam logic [IDX_W-1:0] SPAN_I = IDX_W'(WIN_LEN - 1);

  logic               open_q;
  logic               full_q;
  logic [IDX_W-1:0]   idx_q;
  logic [OFS_W-1:0]   off_q;
  logic [WIN_LEN-1:0] mask_q;

  logic [IDX_W-1:0]   cur_idx;
  logic [IDX_W-1:0]   cur_off;
  logic [WIN_LEN-1:0] cur_mask;
  logic [IDX_W-1:0]   rel;
  logic               in_win;
  logic               end_hit;

  always_comb begin
    beat     = in_valid & (in_sof | open_q);
    restart  = beat & in_sof;
    last     = beat & in_eof;
    cur_idx  = in_sof ? '0 : idx_q;
    cur_off  = in_sof ? {1'b0, cfg_offset} : {1'b0, off_q};
    cur_mask = in_sof ? cfg_mask : mask_q;
    rel      = cur_idx - cur_off;
    in_win   = (cur_idx >= cur_off) && (rel < LEN_I);
    take     = beat && in_win && cur_mask[rel[REL_W-1:0]];
    end_hit  = beat && (cur_idx == cur_off + SPAN_I);
    win_full = end_hit | (~in_sof & full_q);
  end

  assign frame_open = open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      full_q <= 1'b0;
      idx_q  <= '0;
      off_q  <= '0;
      mask_q <= '0;
    end else if (beat) begin
      if (in_sof) begin
        off_q  <= cfg_offset;
        mask_q <= cfg_mask;
      end
      idx_q  <= (cur_idx == '1) ? cur_idx : cur_idx + 1'b1;
      full_q <= win_full;
      open_q <= ~in_eof;
    end
  end

endmodule

// File: rtl/pmf_accum.sv
module pmf_accum
  import pmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              restart,
  input  logic              take,
  input  logic [BYTE_W-1:0] data,
  output word_t             csum
);

  word_t             sum_q, base_sum, nxt_sum;
  logic              pend_q, base_pend, nxt_pend;
  logic [BYTE_W-1:0] hi_q, base_hi, nxt_hi;

  always_comb begin
    base_sum  = restart ? '0 : sum_q;
    base_pend = restart ? 1'b0 : pend_q;
    base_hi   = restart ? '0 : hi_q;
    nxt_sum   = base_sum;
    nxt_pend  = base_pend;
    nxt_hi    = base_hi;
    if (take) begin
      if (base_pend) begin
        nxt_sum  = oc_add(base_sum, {base_hi, data});
        nxt_pend = 1'b0;
      end else begin
        nxt_hi   = data;
        nxt_pend = 1'b1;
      end
    end
    csum = ~oc_add(nxt_sum, nxt_pend ? {nxt_hi, {BYTE_W{1'b0}}} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      pend_q <= 1'b0;
      hi_q   <= '0;
    end else if (beat) begin
      sum_q  <= nxt_sum;
      pend_q <= nxt_pend;
      hi_q   <= nxt_hi;
    end
  end

endmodule

// File: rtl/pmf_decide.sv
module pmf_decide
  import pmf_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  logic  last,
  input  logic  win_full,
  input  word_t csum,
  input  word_t cfg_expect,
  output logic  res_valid,
  output logic  res_match
);

  word_t exp_q;
  word_t cur_exp;

  assign cur_exp = restart ? cfg_expect : exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q     <= '0;
      res_valid <= 1'b0;
      res_match <= 1'b0;
    end else begin
      if (restart) exp_q <= cfg_expect;
      res_valid <= last;
      res_match <= last & win_full & (csum == cur_exp);
    end
  end

endmodule

// File: rtl/pmf_match_top.sv
module pmf_match_top
  import pmf_pkg::*;
#(
  parameter int OFS_W   = 16,
  parameter int WIN_LEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic               in_eof,
  input  logic [7:0]         in_data,
  input  logic [OFS_W-1:0]   cfg_offset,
  input  logic [WIN_LEN-1:0] cfg_mask,
  input  logic [15:0]        cfg_expect,
  output logic               res_valid,
  output logic               res_match
);

  logic  beat, restart, take, last, win_full, frame_open;
  word_t csum;

  pmf_window #(.OFS_W(OFS_W), .WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .cfg_offset(cfg_offset), .cfg_mask(cfg_mask),
    .beat(beat), .restart(restart), .take(take), .last(last),
    .win_full(win_full), .frame_open(frame_open)
  );

  pmf_accum u_acc (
    .clk(clk), .rst(rst), .beat(beat), .restart(restart), .take(take),
    .data(in_data), .csum(csum)
  );

  pmf_decide u_dec (
    .clk(clk), .rst(rst), .restart(restart), .last(last),
    .win_full(win_full), .csum(csum), .cfg_expect(cfg_expect),
    .res_valid(res_valid), .res_match(res_match)
  );

endmodule

// File: rtl/pmf_match_chk.sv
module pmf_match_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_sof,
  input logic in_eof,
  input logic frame_open,
  input logic win_full,
  input logic res_valid,
  input logic res_match
);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !res_match));

  a_r8_strobe_after_eof: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && (in_sof || frame_open)) |=> res_valid);

  a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_eof));

  a_r8_match_in_strobe: assert property (@(posedge clk) disable iff (rst)
    res_match |-> res_valid);

  a_r7_match_needs_window: assert property (@(posedge clk) disable iff (rst)
    res_match |-> $past(win_full));

endmodule

bind pmf_match_top pmf_match_chk u_chk (.*);

// File: tb/test_pmf_match_top.sv
module test_pmf_match_top;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_W      = 16;
  localparam int WIN_LEN    = 64;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]         in_data = '0;
  logic [OFS_W-1:0]   cfg_offset = '0;
  logic [WIN_LEN-1:0] cfg_mask = '0;
  logic [15:0]        cfg_expect = '0;
  logic               res_valid, res_match;

  pmf_match_top #(.OFS_W(OFS_W), .WIN_LEN(WIN_LEN)) i_pmf_match_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] frame_q[$];
  int         exp_cyc_q[$];
  bit         exp_m_q[$];
  string      exp_r_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, n_sent = 0, n_seen = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // independent reference: returns {window_complete, checksum}
  function automatic logic [16:0] model(input int off, input logic [63:0] mask);
    int n;
    bit ok;
    logic [7:0] inc[$];
    int unsigned s;
    logic [15:0] w;
    n = frame_q.size();
    ok = (off + 63 < n);
    for (int k = 0; k < 64; k++)
      if (mask[k] && off + k < n) inc.push_back(frame_q[off+k]);
    if (inc.size() % 2 == 1) inc.push_back(8'h00);
    s = 0;
    for (int j = 0; j < inc.size(); j += 2) s += {inc[j], inc[j+1]};
    while (s >> 16 != 0) s = (s & 32'hFFFF) + (s >> 16);
    w = ~s[15:0];
    return {ok, w};
  endfunction

  task automatic send_frame(input int off, input logic [63:0] mask,
                            input logic [15:0] expv, input bit gaps,
                            input int chg_at, input string req);
    logic [16:0] m;
    int n;
    m = model(off, mask);
    n = frame_q.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gaps && i > 0 && ($urandom % 3 == 0)) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      in_data  = frame_q[i];
      if (i == 0) begin
        cfg_offset = OFS_W'(off); cfg_mask = mask; cfg_expect = expv;
      end
      if (i == chg_at) begin
        cfg_offset = OFS_W'(off + 2); cfg_mask = ~mask; cfg_expect = ~expv;
      end
      if (i == n - 1) begin
        exp_cyc_q.push_back(cyc + 1);
        exp_m_q.push_back(m[16] && (m[15:0] == expv));
        exp_r_q.push_back(req);
        n_sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic build_rand(input int n);
    frame_q.delete();
    for (int i = 0; i < n; i++) frame_q.push_back(8'($urandom));
  endtask

  task automatic build_doc1(input int n);
    frame_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88,
                8'h99, 8'hAA, 8'hBB, 8'hCC, 8'h00, 8'h5A, 8'h09, 8'h0A,
                8'h0B, 8'h0C, 8'h0D};
    while (frame_q.size() < n) frame_q.push_back(8'(frame_q.size() + 8'h30));
  endtask

  task automatic build_doc2(input int n);
    frame_q = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC,
                8'h00, 8'h04, 8'hA3, 8'hFF, 8'hFF, 8'hFF};
    while (frame_q.size() < n) frame_q.push_back(8'($urandom));
  endtask

  // scoreboard monitor
  int    mon_c;
  bit    mon_m;
  string mon_r;
  always @(negedge clk) begin
    if (!rst) begin
      if (res_match && !res_valid) check(1'b0, "R8", "match outside strobe", 1, 0);
      if (res_valid) begin
        n_seen++;
        if (exp_m_q.size() == 0) begin
          check(1'b0, "R11", "unexpected result strobe", 1, 0);
        end else begin
          mon_c = exp_cyc_q.pop_front();
          mon_m = exp_m_q.pop_front();
          mon_r = exp_r_q.pop_front();
          check(mon_c == cyc, "R8", "strobe cycle", cyc, mon_c);
          check(res_match == mon_m, mon_r, "match flag", res_match, mon_m);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [16:0] m;
    int n, off;
    logic [63:0] mk;
    repeat (4) @(negedge clk);
    check(res_valid == 0 && res_match == 0, "R1", "outputs in reset", {res_valid, res_match}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 0 && res_match == 0, "R1", "outputs after reset", {res_valid, res_match}, 0);

    // R3 R4 R5: skipped bytes repacked, odd count padded
    build_doc1(72);
    m = model(6, 64'h1F0A);
    check(m[15:0] == 16'h563F, "R5", "reference checksum case 1", m[15:0], 16'h563F);
    send_frame(6, 64'h1F0A, 16'h563F, 0, -1, "R4");
    send_frame(6, 64'h1F0A, 16'h563E, 0, -1, "R6");

    // R2 R7: window ending exactly on the last byte, then one short
    build_doc2(64);
    m = model(0, 64'hFC0);
    check(m[15:0] == 16'h5BFC, "R5", "reference checksum case 2", m[15:0], 16'h5BFC);
    send_frame(0, 64'hFC0, 16'h5BFC, 0, -1, "R2");
    build_doc2(70);
    send_frame(6, 64'h3F, 16'h5BFC, 0, -1, "R2");
    build_doc2(69);
    send_frame(6, 64'h3F, 16'h5BFC, 0, -1, "R7");

    // R7: empty mask, long versus short
    build_rand(80);
    send_frame(4, 64'h0, 16'hFFFF, 0, -1, "R7");
    build_rand(67);
    send_frame(4, 64'h0, 16'hFFFF, 0, -1, "R7");
    frame_q = '{8'h55};
    send_frame(0, 64'h0, 16'hFFFF, 0, -1, "R7");

    // R9: configuration changed inside the frame
    build_doc1(72);
    send_frame(6, 64'h1F0A, 16'h563F, 0, 20, "R9");

    // R10: restart mid-frame
    build_rand(30);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = frame_q[i];
      cfg_offset = 0; cfg_mask = '1; cfg_expect = 16'h0;
    end
    build_doc1(72);
    send_frame(6, 64'h1F0A, 16'h563F, 0, -1, "R10");

    // R11: bytes outside a frame, then a frame with idle gaps
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 5); in_data = 8'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_m_q.size() == 0 && n_seen == n_sent, "R11", "no result from stray bytes", n_seen, n_sent);
    build_doc1(72);
    send_frame(6, 64'h1F0A, 16'h563F, 1, -1, "R11");

    // R3 R5 R6: random masks and offsets
    for (int t = 0; t < 10; t++) begin
      n = 64 + $urandom % 40;
      off = 2 * ($urandom % 22);
      build_rand(n);
      mk = {32'($urandom), 32'($urandom)};
      m = model(off, mk);
      send_frame(off, mk, (t % 3 == 0) ? m[15:0] ^ 16'h0100 : m[15:0], t[0], -1, "R3");
    end

    repeat (4) @(negedge clk);
    check(exp_m_q.size() == 0, "R8", "all results delivered", exp_m_q.size(), 0);
    check(n_seen == n_sent, "R8", "strobe count", n_seen, n_sent);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule